// File: doc/BRIEF.md
# Baud Pacing Timer with Serial Bit Latches

The block is an 8-bit up-counter with a software-loaded reload value, used to pace bit-level serial transfers, to count external pulses, or as a plain interval timer. A source selector chooses what advances the counter: every system clock, a pulse on an auxiliary slow-clock tick input, a rising edge on an external input, or every system clock while that external input is high. When the counter passes its all-ones value it reloads from the preload register, raises an interrupt flag, samples the receive line into a receive latch and moves a software-staged bit onto the transmit output. Framing and byte assembly stay in software, which stages one bit per interval.

An optional start-wait mode holds the counter until a falling edge appears on the idle-high receive line. Software then gets its first receive sample one full programmed interval after the start edge. External and receive inputs pass through two-flop synchronisers before use. Software reaches three byte registers over a simple write-strobe bus with a combinational read port.

Top module: `bitpace_timer`

Register map (address: content): 0 control, 1 preload, 2 counter. Control bits: bit0 run, bits 2:1 source (00 system clock, 01 auxiliary tick, 10 external rising edges, 11 system clock gated by external level), bit3 start-wait, bit4 staged transmit bit, bit5 receive latch (read only), bit6 interrupt flag (read; writing 1 clears), bit7 reads 0.

## Requirements
- R1: After reset the counter and preload read 0, control reads 0x20 (receive latch at 1, all other bits 0), tx_out is 1 and irq is 0.
- R2: Any write to address 2 loads the counter from the preload register; the written data has no effect on the counter.
- R3: With run=1 and source 00 the counter rises by one per clock; with run=0 it holds whatever the selected source does.
- R4: An advance from 0xFF reloads the counter from preload and sets the interrupt flag (irq=1), so one interval lasts 256 minus preload advances.
- R5: The preload register may be rewritten straight after a counter load; the running interval is unchanged and the new value is used at the next reload.
- R6: With source 01 the counter rises once per clock in which aux_tick is 1.
- R7: With source 10 the counter rises once per rising edge of ext_in (pulse counting).
- R8: With source 11 the counter rises once per clock in which the synchronised ext_in is 1.
- R9: On each reload the staged transmit bit (control bit4) moves to tx_out and the synchronised rx_in level is stored in the receive latch (control bit5).
- R10: With start-wait set, a control write arms the detector and the counter holds until a falling edge on the synchronised rx_in; counting then proceeds normally.
- R11: Writing control with bit6=1 clears the interrupt flag and irq, unless a reload sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_tick | input | 1 | One-cycle pulse per slow auxiliary clock period, synchronous to clk |
| ext_in | input | 1 | External count input, asynchronous |
| rx_in | input | 1 | Serial receive line, idle high, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| tx_out | output | 1 | Serial transmit bit, updated on reload |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions take for granted that aux_tick is already synchronous to clk and that the external and receive lines only matter after their two synchronising flops, so every relation is stated on the internal advance, load and reload events rather than on raw pins. They also assume a reload and a counter write never coincide in a way that matters, since a load takes priority and suppresses the reload. The stimulus drives inputs only at falling clock edges, holds ext_in and rx_in steady for several cycles around each change so that the synchroniser delay is fixed, and issues one register write per cycle.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  typedef enum logic [1:0] {
    SRC_SYS   = 2'b00,
    SRC_AUX   = 2'b01,
    SRC_EDGE  = 2'b10,
    SRC_GATED = 2'b11
  } src_e;

  // software-written control fields, packed as they sit in bits 4:0
  typedef struct packed {
    logic tx_bit;
    logic start_wait;
    src_e src;
    logic run;
  } ctl_t;

  localparam int unsigned ADDR_CTL = 0;
  localparam int unsigned ADDR_PRE = 1;
  localparam int unsigned ADDR_CNT = 2;
  localparam int unsigned FLAG_BIT = 6;
endpackage

// File: rtl/bpt_sync.sv
module bpt_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {(STAGES+1){RESET_VAL}};
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/bpt_tick_sel.sv
module bpt_tick_sel
  import bpt_pkg::*;
(
  input  src_e src,
  input  logic aux_tick,
  input  logic ext_level,
  input  logic ext_rise,
  output logic tick
);
  always_comb begin
    unique case (src)
      SRC_SYS:   tick = 1'b1;
      SRC_AUX:   tick = aux_tick;
      SRC_EDGE:  tick = ext_rise;
      SRC_GATED: tick = ext_level;
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/bpt_counter.sv
module bpt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] preload,
  output logic [W-1:0] cnt,
  output logic         carry
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] cnt_q;

  assign carry = adv & ~load & (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || carry) cnt_q <= preload;
    else if (adv)          cnt_q <= step(cnt_q);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/bitpace_timer.sv
module bitpace_timer
  import bpt_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aux_tick,
  input  logic              ext_in,
  input  logic              rx_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              tx_out,
  output logic              irq
);
  localparam int unsigned CTL_W = $bits(ctl_t);

  ctl_t         ctl_q;
  logic [W-1:0] pre_q;
  logic         flag_q, rxl_q, tx_q, go_q;

  logic ext_level, ext_rise, ext_fall;
  logic rx_level, rx_rise, rx_fall;
  logic tick, adv, ld, carry, waiting;
  logic [W-1:0] cnt_w;
  logic wr_ctl, wr_pre;
  logic unused_inputs;

  assign wr_ctl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTL));
  assign wr_pre = reg_wr && (reg_addr == ADDR_W'(ADDR_PRE));
  assign ld     = reg_wr && (reg_addr == ADDR_W'(ADDR_CNT));

  bpt_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b0)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_in),
    .level(ext_level), .rise(ext_rise), .fall(ext_fall));

  bpt_sync #(.STAGES(SYNC_N), .RESET_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in),
    .level(rx_level), .rise(rx_rise), .fall(rx_fall));

  bpt_tick_sel u_sel (
    .src(ctl_q.src), .aux_tick(aux_tick),
    .ext_level(ext_level), .ext_rise(ext_rise), .tick(tick));

  assign waiting = ctl_q.start_wait & ~go_q;
  assign adv     = ctl_q.run & tick & ~waiting;

  bpt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ld), .adv(adv),
    .preload(pre_q), .cnt(cnt_w), .carry(carry));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      pre_q  <= '0;
      flag_q <= 1'b0;
      rxl_q  <= 1'b1;
      tx_q   <= 1'b1;
      go_q   <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_t'(reg_wdata[CTL_W-1:0]);
      if (wr_pre) pre_q <= reg_wdata;
      if (carry)
        flag_q <= 1'b1;
      else if (wr_ctl && reg_wdata[FLAG_BIT])
        flag_q <= 1'b0;
      if (carry) begin
        rxl_q <= rx_level;
        tx_q  <= ctl_q.tx_bit;
      end
      if (wr_ctl)
        go_q <= 1'b0;
      else if (ctl_q.start_wait && rx_fall)
        go_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTL))
      reg_rdata = {{(W-7){1'b0}}, flag_q, rxl_q, ctl_q};
    else if (reg_addr == ADDR_W'(ADDR_PRE))
      reg_rdata = pre_q;
    else if (reg_addr == ADDR_W'(ADDR_CNT))
      reg_rdata = cnt_w;
  end

  assign tx_out = tx_q;
  assign irq    = flag_q;
  assign unused_inputs = ^{reg_wdata[W-1:FLAG_BIT+1], reg_wdata[5],
                           ext_fall, rx_rise};
endmodule

// File: rtl/bitpace_timer_chk.sv
module bitpace_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] preload,
  input logic         adv,
  input logic         ld,
  input logic         carry,
  input logic         flag,
  input logic         tx_out,
  input logic         tx_bit,
  input logic         waiting
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(preload));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && !carry) |=> cnt == ($past(cnt) + ONE));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld) |=> cnt == $past(cnt));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (cnt == $past(preload)) && flag);

  assert_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> tx_out == $past(tx_bit));

  assert_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !adv);
endmodule

bind bitpace_timer bitpace_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .preload(pre_q),
  .adv(adv), .ld(ld), .carry(carry), .flag(flag_q),
  .tx_out(tx_out), .tx_bit(ctl_q.tx_bit), .waiting(waiting));

// File: tb/bitpace_timer_bench.sv
module bitpace_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aux_tick = 1'b0;
  logic       ext_in = 1'b0;
  logic       rx_in = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_out, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  bitpace_timer u_bitpace_timer (
    .clk(clk), .rst_n(rst_n), .aux_tick(aux_tick), .ext_in(ext_in),
    .rx_in(rx_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_out(tx_out), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd2, v); check("R1 counter", v, 8'h00);
    rd(2'd1, v); check("R1 preload", v, 8'h00);
    rd(2'd0, v); check("R1 control", v, 8'h20);
    check("R1 tx_out", {7'd0, tx_out}, 8'h01);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_load();
    logic [7:0] v;
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hA5);
    rd(2'd2, v); check("R2 load ignores data", v, 8'h3C);
  endtask

  task automatic t_run_hold();
    logic [7:0] v;
    wr(2'd0, 8'h01);
    idle(5);
    rd(2'd2, v); check("R3 five increments", v, 8'h41);
    wr(2'd0, 8'h00);           // this edge still counts
    idle(5);
    rd(2'd2, v); check("R3 hold when stopped", v, 8'h42);
  endtask

  task automatic t_interval();
    logic [7:0] v;
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hF8);           // R5: rewrite right after load
    wr(2'd0, 8'h01);
    idle(15);
    rd(2'd2, v); check("R4 at top", v, 8'hFF);
    check("R4 no flag yet", {7'd0, irq}, 8'h00);
    idle(1);
    rd(2'd2, v); check("R5 reload uses new preload", v, 8'hF8);
    check("R4 flag on reload", {7'd0, irq}, 8'h01);
    idle(7);
    rd(2'd2, v); check("R5 second interval top", v, 8'hFF);
    idle(1);
    rd(2'd2, v); check("R4 second reload", v, 8'hF8);
    wr(2'd0, 8'h40);
    check("R11 flag cleared", {7'd0, irq}, 8'h00);
    rd(2'd0, v); check("R11 control flag bit", v & 8'h40, 8'h00);
  endtask

  task automatic t_serial();
    logic [7:0] v;
    rx_in = 1'b0;
    idle(4);
    wr(2'd1, 8'hFC);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);           // tx bit 0, run
    idle(4);
    check("R9 tx takes staged 0", {7'd0, tx_out}, 8'h00);
    rd(2'd0, v); check("R9 rx latch 0", v & 8'h20, 8'h00);
    rx_in = 1'b1;
    idle(3);
    wr(2'd0, 8'h11);           // tx bit 1, run
    idle(8);
    check("R9 tx takes staged 1", {7'd0, tx_out}, 8'h01);
    rd(2'd0, v); check("R9 rx latch 1", v & 8'h20, 8'h20);
    wr(2'd0, 8'h50);
  endtask

  task automatic t_start();
    logic [7:0] v;
    wr(2'd1, 8'hFC);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h09);           // start-wait, run
    idle(10);
    rd(2'd2, v); check("R10 held while line idle", v, 8'hFC);
    check("R10 no flag while waiting", {7'd0, irq}, 8'h00);
    rx_in = 1'b0;
    idle(10);
    check("R10 counting after start edge", {7'd0, irq}, 8'h01);
    rd(2'd0, v); check("R10 first sample is start level", v & 8'h20, 8'h00);
    wr(2'd0, 8'h40);
    rx_in = 1'b1;
    idle(4);
  endtask

  task automatic aux_pulse();
    aux_tick = 1'b1; @(negedge clk);
    aux_tick = 1'b0; @(negedge clk);
  endtask

  task automatic t_aux();
    logic [7:0] v;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h00);
    for (int i = 0; i < 3; i++) aux_pulse();
    rd(2'd2, v); check("R3 aux ignored when stopped", v, 8'h00);
    wr(2'd0, 8'h03);
    for (int i = 0; i < 7; i++) aux_pulse();
    rd(2'd2, v); check("R6 aux pulses counted", v, 8'h07);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] v;
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05);
    for (int i = 0; i < 5; i++) begin
      ext_in = 1'b1; idle(4);
      ext_in = 1'b0; idle(4);
    end
    idle(4);
    rd(2'd2, v); check("R7 rising edges counted", v, 8'h05);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_gated();
    logic [7:0] v;
    wr(2'd0, 8'h06);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h07);
    ext_in = 1'b1; idle(20);
    ext_in = 1'b0; idle(6);
    rd(2'd2, v); check("R8 high cycles counted", v, 8'd20);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_load();
    t_run_hold();
    t_interval();
    t_serial();
    t_start();
    t_aux();
    t_edge();
    t_gated();
    idle(5);
    finish_run();
  end
endmodule